// File: doc/BRIEF.md
# Branch Target Prediction Buffer

This block sits beside the instruction-fetch stage of a pipelined processor. Each cycle the fetch unit presents the address it is about to fetch. The block answers without a clock delay: whether the address hits a stored branch, whether that branch is predicted taken, and the next fetch address. The next fetch address is the stored target on a taken prediction and the sequential successor otherwise. The block keeps no notion of branch kind. Conditional branches and unconditional jumps allocate, predict and train in exactly the same way.

When a branch resolves in execute, the pipeline reports its address, actual direction and actual target. The block compares that report with the prediction its table would give for that address. It reports the cycle penalty the branch cost: zero for a hit with a correct prediction, three for a miss or a wrong prediction. It then allocates or trains the entry. A parameter picks a one-bit last-outcome scheme or a two-bit saturating-counter scheme. Three saturating statistics counters accumulate resolved branches, mispredictions and penalty cycles, so software models can derive misprediction rates.

Top module: `bpb_top`

## Requirements
- R1: After reset no entry is valid, so every lookup reports lk_hit=0, lk_taken=0 and lk_target_vld=0 until a branch has resolved.
- R2: The entry index is pc[ALIGN+IDX_W-1:ALIGN] and the tag is pc[31:ALIGN+IDX_W]. A valid entry whose tag differs from the address is a miss. A resolve at such an address replaces the entry.
- R3: With TWO_BIT=0 a hit predicts the direction of the last resolve of that entry.
- R4: With TWO_BIT=1 each entry holds a counter with the encoding 0 strong-not-taken, 1 weak-not-taken, 2 weak-taken, 3 strong-taken. A taken resolve counts up and a not-taken resolve counts down, saturating at 3 and 0. The prediction is counter bit 1.
- R5: A resolve that misses allocates the entry with its tag and target. With TWO_BIT=0 the stored bit is the actual direction. With TWO_BIT=1 the counter becomes 2 if the branch was taken and 1 if it was not. A lookup of that address in the next cycle hits.
- R6: A hitting resolve that was taken overwrites the stored target with rs_target. A hitting resolve that was not taken leaves the stored target unchanged.
- R7: lk_target_vld is 1 only on a hit predicted taken, and lk_target is then the stored target. Otherwise lk_target is lk_pc + 2**ALIGN.
- R8: While rs_valid is 1, rs_penalty is 0 when the resolving address hits, the predicted direction equals the actual direction and, if taken, the stored target equals rs_target. In all other resolve cases rs_penalty is 3. rs_penalty is 0 while rs_valid is 0.
- R9: Each resolve adds 1 to br_count and adds rs_penalty to pen_total. It adds 1 to mis_count when the predicted direction differs from the actual one or a taken prediction carries the wrong target. A miss predicts not-taken.
- R10: All three counters saturate at 2**CNT_W-1. stat_clr zeroes them at the next edge and overrides any increment in that cycle.
- R11: A lookup and a resolve of the same address in one cycle return the entry as it was before that resolve.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stat_clr | input | 1 | Synchronous clear of the statistics counters |
| lk_pc | input | 32 | Fetch address being looked up |
| lk_hit | output | 1 | Lookup address matches a valid entry |
| lk_taken | output | 1 | Lookup predicted taken |
| lk_target_vld | output | 1 | lk_target comes from the buffer |
| lk_target | output | 32 | Next fetch address |
| rs_valid | input | 1 | A branch resolves this cycle |
| rs_pc | input | 32 | Address of the resolving branch |
| rs_taken | input | 1 | Actual direction |
| rs_target | input | 32 | Actual target |
| rs_penalty | output | 2 | Penalty cycles of the resolving branch (0 or 3) |
| br_count | output | CNT_W | Branches resolved |
| mis_count | output | CNT_W | Mispredictions |
| pen_total | output | CNT_W | Accumulated penalty cycles |

## Verification
The first stimulus is a counted loop: a backward branch taken nine times and then falling through, plus an always-taken jump. This pattern separates the one-bit scheme, which misses twice per loop exit and re-entry, from the two-bit scheme, which misses once. An alternating taken/not-taken branch shows the counter hysteresis that the one-bit bit lacks. Aliasing addresses with one index and different tags check that a tag mismatch is a miss and evicts the entry. A target change on an always-taken branch separates the direction check from the target check. A long pseudo-random stream over a few aliasing addresses, with small counters, drives saturation and clears that collide with resolves.

// File: rtl/bpb_pkg.sv
package bpb_pkg;

    parameter int unsigned PC_W         = 32;
    localparam int unsigned PEN_W       = 2;
    localparam logic [PEN_W-1:0] MISS_PEN = 2'd3;

    typedef logic [PC_W-1:0] pc_t;

    typedef enum logic [1:0] {
        CTR_SNT = 2'b00,
        CTR_WNT = 2'b01,
        CTR_WT  = 2'b10,
        CTR_ST  = 2'b11
    } ctr_e;

    // Result of comparing one table entry against an address
    typedef struct packed {
        logic hit;
        logic pred;
        pc_t  target;
        ctr_e ctr;
    } probe_t;

    function automatic logic ctr_predict(ctr_e c);
        return c[1];
    endfunction

    // State written when a resolving branch misses
    function automatic ctr_e ctr_alloc(logic taken, logic two_bit);
        if (!two_bit) return taken ? CTR_ST : CTR_SNT;
        return taken ? CTR_WT : CTR_WNT;
    endfunction

    // State written when a resolving branch hits
    function automatic ctr_e ctr_train(ctr_e cur, logic taken, logic two_bit);
        if (!two_bit) return taken ? CTR_ST : CTR_SNT;
        if (taken)  return (cur == CTR_ST)  ? CTR_ST  : ctr_e'(cur + 2'd1);
        return (cur == CTR_SNT) ? CTR_SNT : ctr_e'(cur - 2'd1);
    endfunction

endpackage

// File: rtl/bpb_store.sv
module bpb_store
    import bpb_pkg::*;
#(
    parameter int unsigned IDX_W = 4,
    parameter int unsigned TAG_W = 26
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] ra_idx,
    output logic             ra_valid,
    output logic [TAG_W-1:0] ra_tag,
    output ctr_e             ra_ctr,
    output pc_t              ra_tgt,
    input  logic [IDX_W-1:0] rb_idx,
    output logic             rb_valid,
    output logic [TAG_W-1:0] rb_tag,
    output ctr_e             rb_ctr,
    output pc_t              rb_tgt,
    input  logic             we,
    input  logic [IDX_W-1:0] w_idx,
    input  logic [TAG_W-1:0] w_tag,
    input  ctr_e             w_ctr,
    input  pc_t              w_tgt
);
    localparam int unsigned DEPTH = 1 << IDX_W;

    logic             valid_q [DEPTH];
    logic [TAG_W-1:0] tag_q   [DEPTH];
    ctr_e             ctr_q   [DEPTH];
    pc_t              tgt_q   [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                valid_q[i] <= 1'b0;
                tag_q[i]   <= '0;
                ctr_q[i]   <= CTR_SNT;
                tgt_q[i]   <= '0;
            end
        end else if (we) begin
            valid_q[w_idx] <= 1'b1;
            tag_q[w_idx]   <= w_tag;
            ctr_q[w_idx]   <= w_ctr;
            tgt_q[w_idx]   <= w_tgt;
        end
    end

    // Reads see the array before the current cycle's write
    assign ra_valid = valid_q[ra_idx];
    assign ra_tag   = tag_q[ra_idx];
    assign ra_ctr   = ctr_q[ra_idx];
    assign ra_tgt   = tgt_q[ra_idx];
    assign rb_valid = valid_q[rb_idx];
    assign rb_tag   = tag_q[rb_idx];
    assign rb_ctr   = ctr_q[rb_idx];
    assign rb_tgt   = tgt_q[rb_idx];

endmodule

// File: rtl/bpb_probe.sv
module bpb_probe
    import bpb_pkg::*;
#(
    parameter int unsigned TAG_W = 26
) (
    input  logic             valid,
    input  logic [TAG_W-1:0] stored_tag,
    input  logic [TAG_W-1:0] addr_tag,
    input  ctr_e             ctr,
    input  pc_t              target,
    output probe_t           res
);
    always_comb begin
        res.hit    = valid && (stored_tag == addr_tag);
        res.pred   = res.hit && ctr_predict(ctr);
        res.target = target;
        res.ctr    = ctr;
    end
endmodule

// File: rtl/bpb_sat_cnt.sv
module bpb_sat_cnt #(
    parameter int unsigned W  = 32,
    parameter int unsigned AW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic [AW-1:0] add,
    output logic [W-1:0]  value
);
    logic [W:0] sum;

    assign sum = {1'b0, value} + (W+1)'(add);

    always_ff @(posedge clk) begin
        if (rst || clr)   value <= '0;
        else if (sum[W])  value <= '1;
        else              value <= sum[W-1:0];
    end
endmodule

// File: rtl/bpb_top.sv
module bpb_top
    import bpb_pkg::*;
#(
    parameter int unsigned IDX_W   = 4,
    parameter int unsigned ALIGN   = 2,
    parameter bit          TWO_BIT = 1'b1,
    parameter int unsigned CNT_W   = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stat_clr,
    input  logic [31:0]      lk_pc,
    output logic             lk_hit,
    output logic             lk_taken,
    output logic             lk_target_vld,
    output logic [31:0]      lk_target,
    input  logic             rs_valid,
    input  logic [31:0]      rs_pc,
    input  logic             rs_taken,
    input  logic [31:0]      rs_target,
    output logic [1:0]       rs_penalty,
    output logic [CNT_W-1:0] br_count,
    output logic [CNT_W-1:0] mis_count,
    output logic [CNT_W-1:0] pen_total
);
    localparam int unsigned TAG_W = PC_W - IDX_W - ALIGN;
    localparam int unsigned TAG_LO = IDX_W + ALIGN;
    localparam pc_t INSN_BYTES = pc_t'(1) << ALIGN;

    logic [IDX_W-1:0] lk_idx, rs_idx;
    logic [TAG_W-1:0] lk_tag, rs_tag;

    assign lk_idx = lk_pc[TAG_LO-1:ALIGN];
    assign rs_idx = rs_pc[TAG_LO-1:ALIGN];
    assign lk_tag = lk_pc[PC_W-1:TAG_LO];
    assign rs_tag = rs_pc[PC_W-1:TAG_LO];

    logic             a_valid, b_valid;
    logic [TAG_W-1:0] a_tag, b_tag;
    ctr_e             a_ctr, b_ctr;
    pc_t              a_tgt, b_tgt;
    logic             wr_en;
    ctr_e             wr_ctr;
    pc_t              wr_tgt;

    bpb_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) store_i (
        .clk(clk), .rst(rst),
        .ra_idx(lk_idx), .ra_valid(a_valid), .ra_tag(a_tag), .ra_ctr(a_ctr), .ra_tgt(a_tgt),
        .rb_idx(rs_idx), .rb_valid(b_valid), .rb_tag(b_tag), .rb_ctr(b_ctr), .rb_tgt(b_tgt),
        .we(wr_en), .w_idx(rs_idx), .w_tag(rs_tag), .w_ctr(wr_ctr), .w_tgt(wr_tgt)
    );

    probe_t lk_res, rs_res;

    bpb_probe #(.TAG_W(TAG_W)) lk_probe_i (
        .valid(a_valid), .stored_tag(a_tag), .addr_tag(lk_tag),
        .ctr(a_ctr), .target(a_tgt), .res(lk_res)
    );

    bpb_probe #(.TAG_W(TAG_W)) rs_probe_i (
        .valid(b_valid), .stored_tag(b_tag), .addr_tag(rs_tag),
        .ctr(b_ctr), .target(b_tgt), .res(rs_res)
    );

    // Fetch-side answer
    assign lk_hit        = lk_res.hit;
    assign lk_taken      = lk_res.pred;
    assign lk_target_vld = lk_res.pred;
    assign lk_target     = lk_res.pred ? lk_res.target : lk_pc + INSN_BYTES;

    // Resolve-side evaluation against the current table contents
    logic mispredict;
    logic costly;

    always_comb begin
        mispredict = (rs_res.pred != rs_taken) ||
                     (rs_res.pred && rs_taken && (rs_res.target != rs_target));
        costly     = !rs_res.hit || mispredict;
        rs_penalty = (rs_valid && costly) ? MISS_PEN : '0;
    end

    // Allocation and training
    assign wr_en  = rs_valid;
    assign wr_tgt = (!rs_res.hit || rs_taken) ? rs_target : rs_res.target;
    assign wr_ctr = rs_res.hit ? ctr_train(rs_res.ctr, rs_taken, TWO_BIT)
                               : ctr_alloc(rs_taken, TWO_BIT);

    // Statistics
    logic [PEN_W-1:0] br_add, mis_add;
    assign br_add  = PEN_W'(rs_valid);
    assign mis_add = PEN_W'(rs_valid && mispredict);

    bpb_sat_cnt #(.W(CNT_W), .AW(PEN_W)) br_cnt_i (
        .clk(clk), .rst(rst), .clr(stat_clr), .add(br_add), .value(br_count)
    );
    bpb_sat_cnt #(.W(CNT_W), .AW(PEN_W)) mis_cnt_i (
        .clk(clk), .rst(rst), .clr(stat_clr), .add(mis_add), .value(mis_count)
    );
    bpb_sat_cnt #(.W(CNT_W), .AW(PEN_W)) pen_cnt_i (
        .clk(clk), .rst(rst), .clr(stat_clr), .add(rs_penalty), .value(pen_total)
    );

endmodule

// File: rtl/bpb_checker.sv
module bpb_checker #(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             stat_clr,
    input logic [31:0]      lk_pc,
    input logic             lk_hit,
    input logic             rs_valid,
    input logic [31:0]      rs_pc,
    input logic [1:0]       rs_penalty,
    input logic [CNT_W-1:0] br_count,
    input logic [CNT_W-1:0] mis_count,
    input logic [CNT_W-1:0] pen_total
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !lk_hit);                                         // R1

    AST_ALLOC_HIT: assert property (@(posedge clk) disable iff (rst)
        rs_valid |=> (lk_pc != $past(rs_pc)) || lk_hit);                 // R5

    AST_PEN_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (rs_penalty == 2'd0) || (rs_valid && rs_penalty == 2'd3));       // R8

    AST_PEN_ACCUM: assert property (@(posedge clk) disable iff (rst)
        (!stat_clr && pen_total <= CMAX - CNT_W'(3))
        |=> pen_total == $past(pen_total) + CNT_W'($past(rs_penalty))); // R8

    AST_BR_STEP: assert property (@(posedge clk) disable iff (rst)
        (rs_valid && !stat_clr && br_count != CMAX)
        |=> br_count == $past(br_count) + CNT_W'(1));                    // R9

    AST_MIS_BOUND: assert property (@(posedge clk) disable iff (rst)
        mis_count <= br_count);                                          // R9

    AST_CLEAR: assert property (@(posedge clk) disable iff (rst)
        stat_clr |=> (br_count == '0 && mis_count == '0 && pen_total == '0)); // R10

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        !stat_clr |=> (pen_total >= $past(pen_total) &&
                       mis_count >= $past(mis_count)));                  // R10

endmodule

bind bpb_top bpb_checker #(.CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst(rst), .stat_clr(stat_clr), .lk_pc(lk_pc), .lk_hit(lk_hit),
    .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_penalty(rs_penalty),
    .br_count(br_count), .mis_count(mis_count), .pen_total(pen_total)
);

// File: tb/bpb_top_tb_top.sv
module bpb_top_tb_top;
    localparam int IDX_W = 4;
    localparam int ALIGN = 2;
    localparam int DEPTH = 1 << IDX_W;
    localparam int CW    = 8;
    localparam longint CMAX = (longint'(1) << CW) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic stat_clr = 1'b0;
    logic [31:0] lk_pc = '0;
    logic rs_valid = 1'b0;
    logic [31:0] rs_pc = '0;
    logic rs_taken = 1'b0;
    logic [31:0] rs_target = '0;

    // index 0: one-bit scheme, index 1: two-bit scheme
    logic        o_hit [2];
    logic        o_tk  [2];
    logic        o_tv  [2];
    logic [31:0] o_tgt [2];
    logic [1:0]  o_pen [2];
    logic [CW-1:0] o_br [2];
    logic [CW-1:0] o_mis[2];
    logic [CW-1:0] o_pt [2];

    always #5 clk = ~clk;

    bpb_top #(.IDX_W(IDX_W), .ALIGN(ALIGN), .TWO_BIT(1'b1), .CNT_W(CW)) dut_i (
        .clk(clk), .rst(rst), .stat_clr(stat_clr), .lk_pc(lk_pc),
        .lk_hit(o_hit[1]), .lk_taken(o_tk[1]), .lk_target_vld(o_tv[1]), .lk_target(o_tgt[1]),
        .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_taken(rs_taken), .rs_target(rs_target),
        .rs_penalty(o_pen[1]), .br_count(o_br[1]), .mis_count(o_mis[1]), .pen_total(o_pt[1])
    );

    bpb_top #(.IDX_W(IDX_W), .ALIGN(ALIGN), .TWO_BIT(1'b0), .CNT_W(CW)) dut1_i (
        .clk(clk), .rst(rst), .stat_clr(stat_clr), .lk_pc(lk_pc),
        .lk_hit(o_hit[0]), .lk_taken(o_tk[0]), .lk_target_vld(o_tv[0]), .lk_target(o_tgt[0]),
        .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_taken(rs_taken), .rs_target(rs_target),
        .rs_penalty(o_pen[0]), .br_count(o_br[0]), .mis_count(o_mis[0]), .pen_total(o_pt[0])
    );

    // Behavioural reference state
    bit          m_v   [2][DEPTH];
    int unsigned m_tag [2][DEPTH];
    int unsigned m_tgt [2][DEPTH];
    int          m_ctr [2][DEPTH];
    longint      m_br  [2];
    longint      m_mis [2];
    longint      m_pt  [2];

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int unsigned rng = 32'h1234_5678;

    task automatic chk(string req, string what, int s, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s scheme=%0d actual=%0h expected=%0h", req, what, s, act, exp);
        end
    endtask

    function automatic longint sat(longint v);
        return (v > CMAX) ? CMAX : v;
    endfunction

    task automatic model_reset();
        for (int s = 0; s < 2; s++) begin
            for (int i = 0; i < DEPTH; i++) begin
                m_v[s][i] = 0; m_tag[s][i] = 0; m_tgt[s][i] = 0; m_ctr[s][i] = 0;
            end
            m_br[s] = 0; m_mis[s] = 0; m_pt[s] = 0;
        end
    endtask

    // One cycle: drive, compare every output against the model, advance the model
    task automatic step(string req, int unsigned lpc, bit rv, int unsigned rpc,
                        bit rt, int unsigned rtgt, bit clr);
        @(negedge clk);
        lk_pc = lpc; rs_valid = rv; rs_pc = rpc; rs_taken = rt;
        rs_target = rtgt; stat_clr = clr;
        #1;
        for (int s = 0; s < 2; s++) begin
            int li, ri;
            bit lh, lt, rh, rp, mis;
            int unsigned exp_tgt;
            int pen;
            li = int'((lpc >> ALIGN) % DEPTH);
            ri = int'((rpc >> ALIGN) % DEPTH);
            lh = m_v[s][li] && (m_tag[s][li] == (lpc >> (ALIGN + IDX_W)));
            lt = lh && (m_ctr[s][li] >= 2);
            exp_tgt = lt ? m_tgt[s][li] : lpc + (1 << ALIGN);
            rh = m_v[s][ri] && (m_tag[s][ri] == (rpc >> (ALIGN + IDX_W)));
            rp = rh && (m_ctr[s][ri] >= 2);
            mis = (rp != rt) || (rp && rt && (m_tgt[s][ri] != rtgt));
            pen = (rv && (!rh || mis)) ? 3 : 0;

            chk(req, "lk_hit (R2)", s, longint'(o_hit[s]), longint'(lh));
            chk(req, s == 0 ? "lk_taken (R3)" : "lk_taken (R4)", s, longint'(o_tk[s]), longint'(lt));
            chk(req, "lk_target_vld (R7)", s, longint'(o_tv[s]), longint'(lt));
            chk(req, "lk_target (R7)", s, longint'(o_tgt[s]), longint'(exp_tgt));
            chk(req, "rs_penalty (R8)", s, longint'(o_pen[s]), longint'(pen));
            chk(req, "br_count (R9)", s, longint'(o_br[s]), m_br[s]);
            chk(req, "mis_count (R9)", s, longint'(o_mis[s]), m_mis[s]);
            chk(req, "pen_total (R10)", s, longint'(o_pt[s]), m_pt[s]);

            if (clr) begin
                m_br[s] = 0; m_mis[s] = 0; m_pt[s] = 0;
            end else begin
                m_br[s]  = sat(m_br[s] + (rv ? 1 : 0));
                m_mis[s] = sat(m_mis[s] + ((rv && mis) ? 1 : 0));
                m_pt[s]  = sat(m_pt[s] + pen);
            end
            if (rv) begin
                if (!rh) m_ctr[s][ri] = (s == 0) ? (rt ? 3 : 0) : (rt ? 2 : 1);
                else if (s == 0) m_ctr[s][ri] = rt ? 3 : 0;
                else if (rt) m_ctr[s][ri] = (m_ctr[s][ri] == 3) ? 3 : m_ctr[s][ri] + 1;
                else         m_ctr[s][ri] = (m_ctr[s][ri] == 0) ? 0 : m_ctr[s][ri] - 1;
                if (!rh || rt) m_tgt[s][ri] = rtgt;
                m_v[s][ri]   = 1;
                m_tag[s][ri] = rpc >> (ALIGN + IDX_W);
            end
        end
    endtask

    function automatic int unsigned next_rng(int unsigned x);
        x ^= x << 13; x ^= x >> 17; x ^= x << 5;
        return x;
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        int unsigned pcs [8];
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: empty after reset
        for (int k = 0; k < 8; k++) step("R1", 32'h200 + k * 36, 0, 0, 0, 0, 0);

        // R3 R4 R11: counted loop, branch at 0x100 taken 9 times, jump at 0x10c always
        for (int rep = 0; rep < 2; rep++) begin
            for (int it = 0; it < 10; it++) begin
                step("R11", 32'h100, 1, 32'h100, it < 9, 32'h0f0, 0);
                step("R3 R4", 32'h100, 0, 0, 0, 0, 0);
                step("R11", 32'h10c, 1, 32'h10c, 1, 32'h0c0, 0);
            end
        end

        // R2 R5: alias at same index, different tag; then re-lookup original
        step("R2 R5", 32'h140, 1, 32'h140, 1, 32'h400, 0);
        step("R2 R5", 32'h140, 0, 0, 0, 0, 0);
        step("R2", 32'h100, 0, 0, 0, 0, 0);
        step("R5", 32'h180, 1, 32'h180, 0, 32'h500, 0);
        step("R5", 32'h180, 0, 0, 0, 0, 0);

        // R4: alternating directions
        for (int k = 0; k < 12; k++) begin
            step("R4", 32'h220, 1, 32'h220, k[0], 32'h330, 0);
            step("R4", 32'h220, 0, 0, 0, 0, 0);
        end

        // R6 R7: target changes on taken, held on not-taken
        step("R6", 32'h0, 1, 32'h3c0, 1, 32'h1000, 0);
        step("R6", 32'h3c0, 1, 32'h3c0, 1, 32'h1000, 0);
        step("R6", 32'h3c0, 1, 32'h3c0, 1, 32'h2000, 0);
        step("R7", 32'h3c0, 0, 0, 0, 0, 0);
        step("R6", 32'h3c0, 1, 32'h3c0, 0, 32'h3000, 0);
        step("R7", 32'h3c0, 0, 0, 0, 0, 0);

        // R10: clear colliding with a resolve
        step("R10", 32'h3c0, 1, 32'h3c0, 1, 32'h4000, 1);
        step("R10", 32'h3c0, 0, 0, 0, 0, 0);

        // R9 R10: pseudo-random stream over aliasing addresses, drives saturation
        pcs = '{32'h100, 32'h140, 32'h104, 32'h1104, 32'h220, 32'h3c0, 32'h10c, 32'h84c};
        for (int k = 0; k < 3000; k++) begin
            int unsigned r;
            rng = next_rng(rng);
            r = rng;
            step("R9 R10", pcs[r[2:0]], r[3], pcs[r[6:4]], r[7] | r[8],
                 r[9] ? 32'h800 : 32'h900, (k == 1500));
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule